// File: doc/BRIEF.md
# Host-Polled Sensor Register Bridge

This block gives a host controller a small register window through which it reaches the registers of a camera sensor on a two-wire, open-drain serial control bus. The host stores the target's device address and an index (plus a value, for a write), then writes an opcode. The block runs the whole bus transfer: start condition, address byte, index byte, and either a data byte or a repeated start with a one-byte read. The outcome is posted in a status register that the host polls.

Writes and reads use separate index registers and separate opcodes. Each direction has its own success code, and one shared code reports a missing acknowledge. A read leaves the fetched byte in a dedicated read-data register. An enable register gates the whole engine. While it holds a low value (0x00 or 0x01), opcodes are dropped. The bus clock is derived from the system clock by a parameterised divider. Each bit slot is four quarter-periods of `CLK_DIV` system clocks.

Top module: `sccb_reg_bridge`

## Requirements
- R1: The window decodes offsets as follows: 0 opcode, 1 status, 2 enable, 3 device address, 4 write index, 5 write value, 8 read index, 9 read data. Offsets 2, 3, 4, 5 and 8 read back what was last written. Offset 0 and every unmapped offset read 0x00. Writes to offsets 1 and 9 have no effect.
- R2: Opcode 0x05 starts a write transfer with this bus sequence: a start, the device address with bit 0 forced to 0, the write index, the write value, and a stop. That is 28 rising SCL edges and one start condition.
- R3: Opcode 0x70 starts a read transfer with this bus sequence: a start, the address with bit 0 cleared, the read index, a stop, a start, the address with bit 0 set, one byte from the device answered with a not-acknowledge, and a stop. That is 38 rising SCL edges and two start conditions.
- R4: Status reads 0x00 from the clock edge that accepts an opcode until the transfer completes.
- R5: A write transfer that completes with every byte acknowledged sets status to 0x04. A read transfer that completes that way sets status to 0x01.
- R6: After a successful read, offset 9 holds the byte the device returned. Offset 9 does not change at any other time.
- R7: While the enable register is 0x00 or 0x01, an opcode write starts no transfer. Status stays as it was and SCL stays high.
- R8: If the device fails to acknowledge a byte, the block issues a stop right after that byte and sets status to 0x80. Offset 9 is left unchanged. With a missing address acknowledge, this gives 10 rising SCL edges and one start.
- R9: The block ignores an opcode written while a transfer is running. It also ignores any opcode value other than 0x05 or 0x70.
- R10: During byte transfers, each SCL high phase lasts exactly 2*CLK_DIV system clocks. SDA changes only while SCL is low, except at start and stop conditions.
- R11: After reset, status and read data are 0x00, enable is 0x00, SCL is high and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW | Register offset within the window |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| scl_o | output | 1 | Serial clock (driven level) |
| sda_low_o | output | 1 | High pulls the data line low; low releases it |
| sda_i | input | 1 | Sampled level of the data line |

## Verification
A wrong step counter or a wrong byte selector shows up at once as a wrong edge count or a wrong start count on the bus, and the device model also stores or returns the wrong byte. All of this is visible when the status poll finishes, within one transfer. A bad acknowledge decision gives a wrong status code: 0x80 where a success code is due, or the reverse. A corrupted read-data hold shows on the next read of offset 9. A broken enable gate or busy guard shows as bus edges during a window in which the bench expects SCL to stay high. It can also show as a changed success code after a transfer that should have ignored the injected opcode.

// File: rtl/sccb_reg_bridge.sv
module sccb_reg_bridge #(
  parameter int CLK_DIV = 4,
  parameter int AW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          scl_o,
  output logic          sda_low_o,
  input  logic          sda_i
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [AW-1:0] A_OP = AW'(0), A_ST = AW'(1), A_EN = AW'(2), A_DEV = AW'(3),
                            A_WI = AW'(4), A_WV = AW'(5), A_RI = AW'(8), A_RD = AW'(9);
  localparam logic [7:0] OP_WR = 8'h05, OP_RD = 8'h70;
  localparam logic [7:0] ST_WOK = 8'h04, ST_ROK = 8'h01, ST_NAK = 8'h80;
  localparam logic [1:0] K_STA = 2'd0, K_WB = 2'd1, K_RB = 2'd2, K_STO = 2'd3;

  logic [7:0] en_q, dev_q, widx_q, wval_q, ridx_q, status_q, rdata_q, rsh_q;
  logic       busy, is_rd, err_q;
  logic [2:0] step_q;
  logic [3:0] bitn_q;
  logic [1:0] qtr_q;
  logic [CW-1:0] cnt_q;
  logic [1:0] kind;
  logic [7:0] tx_byte;
  logic       scl_c, sda_c;

  wire en_ok    = |en_q[7:1];
  wire start_op = reg_wr && reg_addr == A_OP && !busy && en_ok &&
                  (reg_wdata == OP_WR || reg_wdata == OP_RD);
  wire tick     = busy && cnt_q == CW'(CLK_DIV - 1);
  wire [2:0] last_step = is_rd ? 3'd7 : 3'd4;
  wire slot_end = kind == K_STA || kind == K_STO || bitn_q == 4'd8;
  wire tx_bit   = tx_byte[3'd7 - bitn_q[2:0]];

  always_comb begin
    if (!is_rd)
      case (step_q)
        3'd0:                 kind = K_STA;
        3'd1, 3'd2, 3'd3:     kind = K_WB;
        default:              kind = K_STO;
      endcase
    else
      case (step_q)
        3'd0, 3'd4:           kind = K_STA;
        3'd1, 3'd2, 3'd5:     kind = K_WB;
        3'd6:                 kind = K_RB;
        default:              kind = K_STO;
      endcase
  end

  always_comb
    case (step_q)
      3'd1:    tx_byte = {dev_q[7:1], 1'b0};
      3'd2:    tx_byte = is_rd ? ridx_q : widx_q;
      3'd3:    tx_byte = wval_q;
      default: tx_byte = {dev_q[7:1], 1'b1};
    endcase

  always_comb
    case (kind)
      K_STA:   begin scl_c = ~qtr_q[1];      sda_c = qtr_q == 2'd0; end
      K_STO:   begin scl_c = qtr_q != 2'd0;  sda_c = qtr_q[1];      end
      K_WB:    begin scl_c = qtr_q == 2'd1 || qtr_q == 2'd2; sda_c = bitn_q[3] | tx_bit; end
      default: begin scl_c = qtr_q == 2'd1 || qtr_q == 2'd2; sda_c = 1'b1; end
    endcase

  assign scl_o     = busy ? scl_c : 1'b1;
  assign sda_low_o = busy & ~sda_c;

  always_comb
    case (reg_addr)
      A_ST:    reg_rdata = status_q;
      A_EN:    reg_rdata = en_q;
      A_DEV:   reg_rdata = dev_q;
      A_WI:    reg_rdata = widx_q;
      A_WV:    reg_rdata = wval_q;
      A_RI:    reg_rdata = ridx_q;
      A_RD:    reg_rdata = rdata_q;
      default: reg_rdata = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cnt_q <= '0;
    else if (!busy || tick)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; dev_q <= '0; widx_q <= '0; wval_q <= '0; ridx_q <= '0;
      status_q <= '0; rdata_q <= '0; rsh_q <= '0;
      busy <= 1'b0; is_rd <= 1'b0; err_q <= 1'b0;
      step_q <= '0; bitn_q <= '0; qtr_q <= '0;
    end else begin
      if (reg_wr)
        case (reg_addr)
          A_EN:    en_q   <= reg_wdata;
          A_DEV:   dev_q  <= reg_wdata;
          A_WI:    widx_q <= reg_wdata;
          A_WV:    wval_q <= reg_wdata;
          A_RI:    ridx_q <= reg_wdata;
          default: ;
        endcase
      if (start_op) begin
        busy <= 1'b1; is_rd <= reg_wdata == OP_RD; err_q <= 1'b0;
        step_q <= '0; bitn_q <= '0; qtr_q <= '0; status_q <= 8'h00;
      end else if (tick) begin
        qtr_q <= qtr_q + 2'd1;
        if (qtr_q == 2'd2) begin
          if (kind == K_WB && bitn_q == 4'd8) err_q <= err_q | sda_i;
          if (kind == K_RB && !bitn_q[3])     rsh_q <= {rsh_q[6:0], sda_i};
        end
        if (qtr_q == 2'd3) begin
          if (!slot_end) bitn_q <= bitn_q + 4'd1;
          else begin
            bitn_q <= '0;
            if (step_q == last_step) begin
              busy     <= 1'b0;
              status_q <= err_q ? ST_NAK : (is_rd ? ST_ROK : ST_WOK);
              if (is_rd && !err_q) rdata_q <= rsh_q;
            end else
              step_q <= err_q ? last_step : step_q + 3'd1;
          end
        end
      end
    end
  end
endmodule

module sccb_reg_bridge_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          busy,
  input logic          is_rd,
  input logic [7:0]    en_q,
  input logic [7:0]    status_q,
  input logic [7:0]    rdata_q
);
  assert_busy_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status_q == 8'h00);
  assert_done_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (status_q == 8'h01 || status_q == 8'h04 || status_q == 8'h80));
  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rdata_q));
  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(0) && en_q[7:1] == 7'd0 && !busy) |=> !busy);
  assert_nak_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && status_q == 8'h80) |-> $stable(rdata_q));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == AW'(0)) |=> $stable(is_rd));
endmodule

bind sccb_reg_bridge sccb_reg_bridge_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .busy(busy), .is_rd(is_rd), .en_q(en_q), .status_q(status_q), .rdata_q(rdata_q)
);

// File: tb/tb_sccb_reg_bridge.sv
`timescale 1ns/1ps
module tb_sccb_reg_bridge;
  localparam int DIV = 4;
  localparam logic [6:0] SLV = 7'h30;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       scl_o, sda_low_o, slv_low;
  wire        sda_w = ~(sda_low_o | slv_low);

  always #2 clk = ~clk;

  sccb_reg_bridge #(.CLK_DIV(DIV), .AW(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_o(scl_o),
    .sda_low_o(sda_low_o), .sda_i(sda_w));

  int n_chk = 0, n_err = 0;
  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 7 + 3);
  endfunction

  // device model on the bus
  logic [7:0] smem [256];
  int st, bc; logic [7:0] sh, ptr, tx; logic rw, in_ack, pscl, psda;
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) smem[i] = init_val(i);
      st = 0; bc = 0; slv_low = 1'b0; in_ack = 1'b0; pscl = 1'b1; psda = 1'b1;
      sh = '0; ptr = '0; tx = '0; rw = 1'b0;
    end else begin
      if (psda && !sda_w && scl_o && pscl) begin st = 1; bc = 0; in_ack = 0; slv_low = 0; end
      else if (!psda && sda_w && scl_o && pscl) begin st = 0; in_ack = 0; slv_low = 0; end
      else if (scl_o && !pscl) begin
        if (st == 4) bc++;
        else if (st != 0 && !in_ack && bc < 8) begin sh = {sh[6:0], sda_w}; bc++; end
      end else if (!scl_o && pscl) begin
        if (in_ack) begin
          in_ack = 0; slv_low = 0; bc = 0;
          if (st == 1) begin
            if (rw) begin st = 4; tx = smem[ptr]; slv_low = !tx[7]; end else st = 2;
          end else if (st == 2) st = 3;
        end else if (st == 4) slv_low = (bc < 8) ? !tx[7-bc] : 1'b0;
        else if (st != 0 && bc == 8) begin
          if (st == 1) begin
            if (sh[7:1] == SLV) begin rw = sh[0]; slv_low = 1; in_ack = 1; end else st = 0;
          end else if (st == 2) begin ptr = sh; slv_low = 1; in_ack = 1; end
          else begin smem[ptr] = sh; slv_low = 1; in_ack = 1; end
        end
      end
      pscl = scl_o; psda = sda_w;
    end
  end

  // bus activity counters
  logic cnt_clr = 1'b0;
  int rises, starts, bad_hi, hi_run; logic m_scl, m_sda, run_ok;
  always @(negedge clk) begin
    if (!rst_n || cnt_clr) begin
      rises = 0; starts = 0; bad_hi = 0; hi_run = 0; run_ok = 0; m_scl = scl_o; m_sda = sda_w;
    end else begin
      if (scl_o && !m_scl) begin rises++; hi_run = 1; run_ok = 1; end
      else if (scl_o) hi_run++;
      else if (m_scl && run_ok) begin if (hi_run != 2 * DIV) bad_hi++; run_ok = 0; end
      if (m_sda && !sda_w && scl_o && m_scl) starts++;
      if (!scl_o && m_scl) run_ok = run_ok;
      m_scl = scl_o; m_sda = sda_w;
    end
  end

  task automatic host_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic host_rd(logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  typedef struct {
    string tag; logic [7:0] st; logic [7:0] rd; int rises; int starts; int bad;
    logic chk_mem; logic [7:0] midx; logic [7:0] mval;
  } exp_t;
  exp_t sb[$];
  event done_ev;
  logic [7:0] o_st, o_rd; int o_rises, o_starts, o_bad;

  task automatic run_op(exp_t e, logic [7:0] op, logic inject);
    logic [7:0] v;
    int k;
    sb.push_back(e);
    @(negedge clk); cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    host_wr(4'd0, op);
    host_rd(4'd1, v); chk({"R4 busy status ", e.tag}, v, 8'h00);
    if (inject) begin
      repeat (100) @(negedge clk);
      host_wr(4'd0, 8'h70);
      host_rd(4'd1, v); chk("R9 status after opcode while busy", v, 8'h00);
    end
    k = 0; v = 8'h00;
    while (v == 8'h00 && k < 5000) begin @(negedge clk); host_rd(4'd1, v); k++; end
    o_st = v; host_rd(4'd9, o_rd);
    repeat (4) @(negedge clk);
    o_rises = rises; o_starts = starts; o_bad = bad_hi;
    -> done_ev;
    @(negedge clk);
  endtask

  initial forever begin
    exp_t e;
    @(done_ev);
    e = sb.pop_front();
    chk({e.tag, " status"}, o_st, e.st);
    chk({e.tag, " read data"}, o_rd, e.rd);
    chk({e.tag, " scl rises"}, o_rises, e.rises);
    chk({e.tag, " starts"}, o_starts, e.starts);
    chk({"R10 high-phase width ", e.tag}, o_bad, e.bad);
    if (e.chk_mem) chk({e.tag, " device byte"}, smem[e.midx], e.mval);
  end

  task automatic idle_check(string tag, logic [7:0] op, logic [7:0] exp_st);
    logic [7:0] v;
    @(negedge clk); cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    host_wr(4'd0, op);
    repeat (60) @(negedge clk);
    host_rd(4'd1, v); chk({tag, " status kept"}, v, exp_st);
    chk({tag, " no scl edge"}, rises, 0);
    chk({tag, " scl high"}, scl_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    host_rd(4'd1, v); chk("R11 reset status", v, 8'h00);
    host_rd(4'd9, v); chk("R11 reset read data", v, 8'h00);
    host_rd(4'd2, v); chk("R11 reset enable", v, 8'h00);
    chk("R11 reset scl", scl_o, 1);
    chk("R11 reset sda released", sda_low_o, 0);

    idle_check("R7 enable 0x00", 8'h05, 8'h00);
    host_wr(4'd2, 8'h1e); host_wr(4'd3, 8'h60);
    host_wr(4'd4, 8'h12); host_wr(4'd5, 8'ha5); host_wr(4'd8, 8'h34);
    host_wr(4'd1, 8'h77); host_wr(4'd9, 8'h66);
    host_rd(4'd2, v); chk("R1 enable readback", v, 8'h1e);
    host_rd(4'd3, v); chk("R1 address readback", v, 8'h60);
    host_rd(4'd4, v); chk("R1 write index readback", v, 8'h12);
    host_rd(4'd5, v); chk("R1 write value readback", v, 8'ha5);
    host_rd(4'd8, v); chk("R1 read index readback", v, 8'h34);
    host_rd(4'd6, v); chk("R1 unmapped offset", v, 8'h00);
    host_rd(4'd1, v); chk("R1 status not writable", v, 8'h00);
    host_rd(4'd9, v); chk("R1 read data not writable", v, 8'h00);

    run_op('{"R2 R5 write", 8'h04, 8'h00, 28, 1, 0, 1'b1, 8'h12, 8'ha5}, 8'h05, 1'b0);
    run_op('{"R3 R5 R6 read init byte", 8'h01, init_val(8'h34), 38, 2, 1, 1'b0, 8'h0, 8'h0}, 8'h70, 1'b0);
    host_wr(4'd8, 8'h12);
    run_op('{"R3 R6 read written byte", 8'h01, 8'ha5, 38, 2, 1, 1'b0, 8'h0, 8'h0}, 8'h70, 1'b0);
    host_wr(4'd3, 8'h61); host_wr(4'd4, 8'hff); host_wr(4'd5, 8'h00);
    run_op('{"R2 address bit0 forced", 8'h04, 8'ha5, 28, 1, 0, 1'b1, 8'hff, 8'h00}, 8'h05, 1'b0);
    host_wr(4'd8, 8'hff);
    run_op('{"R6 read zero byte", 8'h01, 8'h00, 38, 2, 1, 1'b0, 8'h0, 8'h0}, 8'h70, 1'b0);
    host_wr(4'd8, 8'h12);
    run_op('{"R6 read back a5", 8'h01, 8'ha5, 38, 2, 1, 1'b0, 8'h0, 8'h0}, 8'h70, 1'b0);

    host_wr(4'd3, 8'h42);
    run_op('{"R8 read nak", 8'h80, 8'ha5, 10, 1, 0, 1'b0, 8'h0, 8'h0}, 8'h70, 1'b0);
    host_wr(4'd4, 8'h20); host_wr(4'd5, 8'h5a);
    run_op('{"R8 write nak", 8'h80, 8'ha5, 10, 1, 0, 1'b1, 8'h20, init_val(8'h20)}, 8'h05, 1'b0);

    host_wr(4'd3, 8'h60);
    run_op('{"R9 write with injected opcode", 8'h04, 8'ha5, 28, 1, 0, 1'b1, 8'h20, 8'h5a}, 8'h05, 1'b1);
    idle_check("R9 unknown opcode", 8'h33, 8'h04);
    host_wr(4'd2, 8'h01);
    idle_check("R7 enable 0x01", 8'h70, 8'h04);
    host_wr(4'd2, 8'h00);
    idle_check("R7 enable 0x00 again", 8'h05, 8'h04);

    repeat (10) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule